// File: doc/BRIEF.md
# Eight-bit timer with waveform generation

An 8-bit timer/counter with two output-compare channels. Each channel owns a waveform pin. A 3-bit mode code picks four things: the counting sequence, where the TOP value comes from, when compare values are loaded, and when the overflow flag fires. The timer advances only on a clock cycle where the count-enable tick is high, so an external prescaler sets the count rate.

Software reaches the timer through a small write/read register port. The control register holds the mode code and each channel's 2-bit output action. Each channel has its own compare register. The counter value can be read and written. A strobe register forces a compare match. The overflow and compare-match flags are one-cycle pulses, and an interrupt controller outside the block collects them.

Top module: `tmr8_wavegen`

## Requirements
- R1: After reset, the control, both compare registers and the counter read 0, both waveform outputs are low, and all flags are low.
- R2: The mode code selects the following behaviour. 0 is normal with TOP 0xFF. 1 is phase-correct PWM with TOP 0xFF. 2 is clear-on-match with TOP from compare A. 3 is fast PWM with TOP 0xFF. 5 is phase-correct PWM with TOP from compare A. 7 is fast PWM with TOP from compare A. Codes 4 and 6 behave as normal mode.
- R3: In normal mode, each tick adds one and wraps from 0xFF to 0x00. `ovf_o` pulses in the cycle after a tick that finds the counter at 0xFF.
- R4: In clear-on-match mode, a tick that finds the counter equal to TOP loads 0. Overflow pulses only for a tick at 0xFF.
- R5: In fast PWM, a tick at TOP wraps the counter to 0 and pulses `ovf_o`. With output action 2'b10, a match clears the pin and the wrap sets it. Action 2'b11 does the inverse. When both happen on the same tick, the wrap action wins.
- R6: In phase-correct PWM, the counter counts up to TOP and then down to 0. `ovf_o` pulses for a tick at 0. With action 2'b10, a match while counting up clears the pin and a match while counting down sets it. Action 2'b11 does the inverse.
- R7: In normal and clear-on-match modes, a compare write takes effect at once. In both PWM modes it is held in a buffer and loaded on a tick at TOP.
- R8: A channel's compare flag pulses in the cycle after a tick (with no counter write) that finds the counter equal to the channel's active compare value. No flag pulses without a tick.
- R9: In non-PWM modes, writing 1 to bit c of the strobe register applies channel c's match action at once (channel A is bit 0, channel B is bit 1). This sets no flag and does not clear the counter. In PWM modes the strobe does nothing.
- R10: The strobe register always reads 0.
- R11: In non-PWM modes the match action is 01 toggle, 10 clear, 11 set. Action 00 holds the pin low in every mode, and 01 does nothing in PWM modes.
- R12: The register addresses are 0 control, 1 compare A, 2 compare B, 3 counter, 4 strobe. Control bits [2:0] are the mode code, [4:3] are the channel A action, and [6:5] are the channel B action. All 8 control bits read back as written. A counter write wins over a tick in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write enable |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i`, combinational |
| tick_i | input | 1 | Count enable |
| wave_a_o | output | 1 | Channel A waveform |
| wave_b_o | output | 1 | Channel B waveform |
| ovf_o | output | 1 | Overflow pulse |
| cmp_a_o | output | 1 | Channel A compare-match pulse |
| cmp_b_o | output | 1 | Channel B compare-match pulse |

## Verification
The bench targets the cycle where a fast-PWM wrap and a match land on the same tick. A design that lets the match win there leaves the pin low for a whole period. It checks that a compare write stays invisible in PWM modes until the tick at TOP. A design that loads it early raises a compare flag on a value that should still be buffered. It follows a phase-correct run through both turning points. Mixing up the direction at a match inverts the pin, and putting the overflow at TOP moves the pulse. It also checks that a strobe in clear-on-match mode neither resets the counter nor raises a flag, and that a strobe in a PWM mode leaves the pin untouched.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;
  typedef enum logic [1:0] {SEQ_NORMAL, SEQ_CTC, SEQ_FAST, SEQ_PHASE} seq_e;

  typedef struct packed {
    seq_e seq;
    logic top_a;
  } mode_t;

  localparam logic [1:0] COM_OFF = 2'b00;
  localparam logic [1:0] COM_TGL = 2'b01;
  localparam logic [1:0] COM_CLR = 2'b10;
  localparam logic [1:0] COM_SET = 2'b11;

  localparam logic [2:0] A_CTRL = 3'd0;
  localparam logic [2:0] A_CMP0 = 3'd1;
  localparam logic [2:0] A_CNT  = 3'd3;
  localparam logic [2:0] A_STRB = 3'd4;

  function automatic mode_t decode_mode(input logic [2:0] code);
    mode_t m;
    m.seq   = SEQ_NORMAL;
    m.top_a = 1'b0;
    case (code)
      3'd1: m.seq = SEQ_PHASE;
      3'd2: begin m.seq = SEQ_CTC;   m.top_a = 1'b1; end
      3'd3: m.seq = SEQ_FAST;
      3'd5: begin m.seq = SEQ_PHASE; m.top_a = 1'b1; end
      3'd7: begin m.seq = SEQ_FAST;  m.top_a = 1'b1; end
      default: m.seq = SEQ_NORMAL;
    endcase
    return m;
  endfunction

  function automatic logic is_pwm(input seq_e s);
    return (s == SEQ_FAST) || (s == SEQ_PHASE);
  endfunction
endpackage

// File: rtl/tmr8_counter.sv
module tmr8_counter
  import tmr8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  seq_e         seq_i,
  input  logic [W-1:0] top_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic [W-1:0] cnt_o,
  output logic         down_o,
  output logic         at_top_o,
  output logic         ovf_o
);
  localparam logic [W-1:0] MAXV = {W{1'b1}};
  localparam logic [W-1:0] ONE  = W'(1);

  logic [W-1:0] cnt_q, cnt_d;
  logic         down_q, down_d, ovf_hit;

  assign at_top_o = (cnt_q == top_i);

  always_comb begin
    cnt_d   = cnt_q;
    down_d  = (seq_i == SEQ_PHASE) ? down_q : 1'b0;
    ovf_hit = 1'b0;
    if (load_i) begin
      cnt_d = load_val_i;
    end else if (tick_i) begin
      case (seq_i)
        SEQ_NORMAL: begin
          cnt_d   = cnt_q + ONE;
          ovf_hit = (cnt_q == MAXV);
        end
        SEQ_CTC: begin
          cnt_d   = at_top_o ? '0 : cnt_q + ONE;
          ovf_hit = (cnt_q == MAXV);
        end
        SEQ_FAST: begin
          cnt_d   = at_top_o ? '0 : cnt_q + ONE;
          ovf_hit = at_top_o;
        end
        SEQ_PHASE: begin
          ovf_hit = (cnt_q == '0);
          if (!down_q) begin
            if (cnt_q >= top_i) begin
              down_d = (cnt_q != '0);
              cnt_d  = (cnt_q == '0) ? '0 : cnt_q - ONE;
            end else begin
              cnt_d = cnt_q + ONE;
            end
          end else if (cnt_q == '0) begin
            down_d = 1'b0;
            cnt_d  = (top_i == '0) ? '0 : ONE;
          end else begin
            cnt_d = cnt_q - ONE;
          end
        end
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      down_q <= 1'b0;
      ovf_o  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      down_q <= down_d;
      ovf_o  <= ovf_hit;
    end
  end

  assign cnt_o  = cnt_q;
  assign down_o = down_q;
endmodule

// File: rtl/tmr8_channel.sv
module tmr8_channel
  import tmr8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  seq_e         seq_i,
  input  logic [1:0]   com_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         force_i,
  input  logic         tick_i,
  input  logic         load_i,
  input  logic [W-1:0] cnt_i,
  input  logic         down_i,
  input  logic         at_top_i,
  output logic [W-1:0] buf_o,
  output logic [W-1:0] act_o,
  output logic         hit_o,
  output logic         wave_o
);
  logic [W-1:0] buf_q, act_q;
  logic         wave_q, wave_d, match, step;

  assign step  = tick_i && !load_i;
  assign match = step && (cnt_i == act_q);

  always_comb begin
    wave_d = wave_q;
    case (seq_i)
      SEQ_FAST: begin
        if (match && com_i == COM_CLR) wave_d = 1'b0;
        if (match && com_i == COM_SET) wave_d = 1'b1;
        // wrap to bottom overrides a coincident match
        if (step && at_top_i && com_i == COM_CLR) wave_d = 1'b1;
        if (step && at_top_i && com_i == COM_SET) wave_d = 1'b0;
      end
      SEQ_PHASE: begin
        if (match && com_i == COM_CLR) wave_d = down_i;
        if (match && com_i == COM_SET) wave_d = !down_i;
      end
      default: begin
        if (match || force_i) begin
          case (com_i)
            COM_TGL: wave_d = !wave_q;
            COM_CLR: wave_d = 1'b0;
            COM_SET: wave_d = 1'b1;
            default: wave_d = wave_q;
          endcase
        end
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q  <= '0;
      act_q  <= '0;
      hit_o  <= 1'b0;
      wave_q <= 1'b0;
    end else begin
      if (wr_i) buf_q <= wdata_i;
      if (!is_pwm(seq_i))            act_q <= wr_i ? wdata_i : buf_q;
      else if (step && at_top_i)     act_q <= buf_q;
      hit_o  <= match;
      wave_q <= wave_d;
    end
  end

  assign buf_o  = buf_q;
  assign act_o  = act_q;
  assign wave_o = (com_i != COM_OFF) && wave_q;
endmodule

// File: rtl/tmr8_wavegen.sv
module tmr8_wavegen
  import tmr8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [2:0]   addr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] rdata_o,
  input  logic         tick_i,
  output logic         wave_a_o,
  output logic         wave_b_o,
  output logic         ovf_o,
  output logic         cmp_a_o,
  output logic         cmp_b_o
);
  localparam int NCH = 2;

  logic [W-1:0]           ctrl_q;
  logic [NCH-1:0][W-1:0]  buf_w, act_w;
  logic [NCH-1:0]         hit_w, wave_w;
  logic [W-1:0]           cnt_w, top_w;
  logic                   down_w, at_top_w, load_w;
  mode_t                  mode_w;
  seq_e                   seq_w;

  assign mode_w = decode_mode(ctrl_q[2:0]);
  assign seq_w  = mode_w.seq;
  assign top_w  = mode_w.top_a ? act_w[0] : {W{1'b1}};
  assign load_w = we_i && (addr_i == A_CNT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          ctrl_q <= '0;
    else if (we_i && addr_i == A_CTRL)    ctrl_q <= wdata_i;
  end

  tmr8_counter #(.W(W)) u_cnt (
    .clk_i, .rst_ni, .tick_i,
    .seq_i(seq_w), .top_i(top_w),
    .load_i(load_w), .load_val_i(wdata_i),
    .cnt_o(cnt_w), .down_o(down_w), .at_top_o(at_top_w), .ovf_o(ovf_o)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    tmr8_channel #(.W(W)) u_ch (
      .clk_i, .rst_ni,
      .seq_i(seq_w),
      .com_i(ctrl_q[3+2*c +: 2]),
      .wr_i(we_i && addr_i == A_CMP0 + 3'(c)),
      .wdata_i,
      .force_i(we_i && addr_i == A_STRB && wdata_i[c]),
      .tick_i, .load_i(load_w),
      .cnt_i(cnt_w), .down_i(down_w), .at_top_i(at_top_w),
      .buf_o(buf_w[c]), .act_o(act_w[c]),
      .hit_o(hit_w[c]), .wave_o(wave_w[c])
    );
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_CTRL:          rdata_o = ctrl_q;
      A_CMP0:          rdata_o = buf_w[0];
      A_CMP0 + 3'd1:   rdata_o = buf_w[1];
      A_CNT:           rdata_o = cnt_w;
      default:         rdata_o = '0;
    endcase
  end

  assign wave_a_o = wave_w[0];
  assign wave_b_o = wave_w[1];
  assign cmp_a_o  = hit_w[0];
  assign cmp_b_o  = hit_w[1];
endmodule

// File: rtl/tmr8_wavegen_chk.sv
module tmr8_wavegen_chk
  import tmr8_pkg::*;
#(
  parameter int W = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         we_i,
  input logic [2:0]   addr_i,
  input logic         tick_i,
  input logic [W-1:0] rdata_o,
  input logic         ovf_o,
  input logic         cmp_a_o,
  input logic         cmp_b_o,
  input seq_e         seq,
  input logic [W-1:0] cnt,
  input logic [W-1:0] top,
  input logic [W-1:0] act_a
);
  logic load;
  assign load = we_i && addr_i == A_CNT;

  p_strobe_reads_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == A_STRB) |-> (rdata_o == '0));

  p_force_no_flag_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == A_STRB && !tick_i) |=> (!cmp_a_o && !cmp_b_o));

  p_phase_ovf_bottom_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !load && seq == SEQ_PHASE && cnt != '0) |=> !ovf_o);

  p_fast_wrap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !load && seq == SEQ_FAST && cnt == top) |=> (cnt == '0));

  p_ctc_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !load && seq == SEQ_CTC && cnt == top) |=> (cnt == '0));

  p_pwm_buffer_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_pwm(seq) && !(tick_i && cnt == top)) |=> $stable(act_a));
endmodule

bind tmr8_wavegen tmr8_wavegen_chk #(.W(W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .addr_i(addr_i),
  .tick_i(tick_i), .rdata_o(rdata_o), .ovf_o(ovf_o),
  .cmp_a_o(cmp_a_o), .cmp_b_o(cmp_b_o),
  .seq(seq_w), .cnt(cnt_w), .top(top_w), .act_a(act_w[0])
);

// File: tb/tmr8_wavegen_tb_top.sv
`timescale 1ns/100ps
module tmr8_wavegen_tb_top;
  localparam int K_RD = 0, K_WA = 1, K_WB = 2, K_OVF = 3, K_CA = 4, K_CB = 5;
  localparam logic [2:0] CTRL = 3'd0, CMPA = 3'd1, CMPB = 3'd2, CNT = 3'd3, STRB = 3'd4;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       we = 1'b0, tick = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic       wave_a, wave_b, ovf, cmp_a, cmp_b;

  typedef struct { int kind; logic [7:0] exp; string req; } item_t;
  item_t q[$];
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  tmr8_wavegen dut_i (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .tick_i(tick), .wave_a_o(wave_a), .wave_b_o(wave_b),
    .ovf_o(ovf), .cmp_a_o(cmp_a), .cmp_b_o(cmp_b)
  );

  // monitor: compares queued expectations at the falling edge
  initial forever begin
    @(negedge clk);
    while (q.size() > 0) begin
      item_t it;
      logic [7:0] act;
      it = q.pop_front();
      case (it.kind)
        K_RD:    act = rdata;
        K_WA:    act = {7'd0, wave_a};
        K_WB:    act = {7'd0, wave_b};
        K_OVF:   act = {7'd0, ovf};
        K_CA:    act = {7'd0, cmp_a};
        default: act = {7'd0, cmp_b};
      endcase
      n_chk++;
      if (act !== it.exp) begin
        n_bad++;
        $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, act, it.exp);
      end
    end
  end

  task automatic cyc(input logic w, input logic [2:0] a, input logic [7:0] d, input logic t);
    @(negedge clk); #1;
    we = w; addr = a; wdata = d; tick = t;
    @(posedge clk);
  endtask

  task automatic expect_it(input int k, input logic [7:0] e, input string r);
    item_t it;
    it.kind = k; it.exp = e; it.req = r;
    q.push_back(it);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    cyc(1'b1, a, d, 1'b0);
  endtask

  task automatic tk(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 3'd0, 8'd0, 1'b1);
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] e, input string r);
    cyc(1'b0, a, 8'd0, 1'b0);
    expect_it(K_RD, e, r);
  endtask

  task automatic finish_run();
    @(negedge clk); @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    rd(CTRL, 8'h00, "R1 ctrl"); rd(CMPA, 8'h00, "R1 cmpa");
    rd(CMPB, 8'h00, "R1 cmpb"); rd(CNT, 8'h00, "R1 cnt");
    expect_it(K_WA, 0, "R1 wave_a"); expect_it(K_WB, 0, "R1 wave_b");
    expect_it(K_OVF, 0, "R1 ovf"); expect_it(K_CA, 0, "R1 cmp_a");

    // R3 normal mode wrap and overflow
    wr(CTRL, 8'h08); wr(CMPA, 8'd5); wr(CNT, 8'hFD);
    tk(1); expect_it(K_OVF, 0, "R3 no ovf at FD");
    tk(1); expect_it(K_OVF, 0, "R3 no ovf at FE");
    tk(1); expect_it(K_OVF, 1, "R3 ovf at FF");
    rd(CNT, 8'h00, "R3 wrap");
    // R8 / R11 toggle on match
    wr(CNT, 8'd4);
    tk(1); expect_it(K_CA, 0, "R8 no match at 4");
    tk(1); expect_it(K_CA, 1, "R8 match at 5"); expect_it(K_WA, 1, "R11 toggle");
    rd(CNT, 8'd6, "R3 count");
    wr(CNT, 8'd5); cyc(1'b0, CTRL, 8'd0, 1'b0);
    expect_it(K_CA, 0, "R8 no tick no flag");
    wr(CTRL, 8'h10); wr(CNT, 8'd5); tk(1); expect_it(K_WA, 0, "R11 clear");
    wr(CTRL, 8'h18); wr(CNT, 8'd5); tk(1); expect_it(K_WA, 1, "R11 set");
    wr(CTRL, 8'h00); expect_it(K_WA, 0, "R11 off low");
    // R9 force toggle, R10 strobe reads zero
    wr(CTRL, 8'h08); expect_it(K_WA, 1, "R11 reconnect");
    wr(STRB, 8'h01); expect_it(K_WA, 0, "R9 force toggles"); expect_it(K_CA, 0, "R9 no flag");
    rd(STRB, 8'h00, "R10 strobe zero");

    // R4 clear-on-match
    wr(CTRL, 8'h0A); wr(CMPA, 8'd3); wr(CNT, 8'd0);
    tk(3); rd(CNT, 8'd3, "R4 reach top");
    tk(1); expect_it(K_OVF, 0, "R4 no ovf at top"); rd(CNT, 8'd0, "R4 clear at top");
    wr(CNT, 8'd3); wr(STRB, 8'h01); rd(CNT, 8'd3, "R9 force keeps count");
    wr(CMPA, 8'd10); tk(1); rd(CNT, 8'd4, "R7 immediate top");
    wr(CMPA, 8'hFF); wr(CNT, 8'hFF); tk(1); expect_it(K_OVF, 1, "R4 ovf at max");
    rd(CNT, 8'd0, "R4 wrap at max");

    // R5 / R7 fast PWM, TOP 0xFF
    wr(CTRL, 8'h13); wr(CMPA, 8'h10); wr(CNT, 8'h10);
    tk(1); expect_it(K_CA, 0, "R7 compare buffered");
    wr(CNT, 8'hFF);
    tk(1); expect_it(K_OVF, 1, "R5 ovf at top"); expect_it(K_CA, 1, "R8 old value match");
    expect_it(K_WA, 1, "R5 wrap wins");
    rd(CNT, 8'd0, "R5 wrap");
    wr(CNT, 8'h10); tk(1); expect_it(K_CA, 1, "R7 loaded at top"); expect_it(K_WA, 0, "R5 clear on match");

    // R5 fast PWM, TOP from compare A
    wr(CTRL, 8'h57); rd(CTRL, 8'h57, "R12 ctrl readback");
    wr(CMPB, 8'd4); wr(CNT, 8'h10);
    tk(1); expect_it(K_OVF, 1, "R5 ovf at A top"); expect_it(K_WB, 1, "R5 set at bottom");
    expect_it(K_CB, 0, "R7 b buffered");
    rd(CNT, 8'd0, "R2 top from A");
    tk(4); expect_it(K_CB, 0, "R8 b not yet");
    tk(1); expect_it(K_CB, 1, "R8 b match"); expect_it(K_WB, 0, "R5 b clear");

    // R6 phase correct, TOP from compare A
    wr(CTRL, 8'h15); wr(CMPA, 8'd4); wr(CNT, 8'h10);
    tk(1); expect_it(K_WA, 0, "R6 up match clears"); expect_it(K_CA, 1, "R6 flag at top");
    expect_it(K_OVF, 0, "R6 no ovf at top");
    rd(CNT, 8'h0F, "R6 turn down");
    tk(11); rd(CNT, 8'd4, "R6 count down");
    tk(1); expect_it(K_CA, 1, "R6 down match"); expect_it(K_WA, 1, "R6 down match sets");
    wr(STRB, 8'h01); expect_it(K_WA, 1, "R9 force ignored in pwm");
    tk(3); rd(CNT, 8'd0, "R6 reach bottom");
    tk(1); expect_it(K_OVF, 1, "R6 ovf at bottom"); rd(CNT, 8'd1, "R6 turn up");
    tk(3); tk(1); expect_it(K_WA, 0, "R6 up match clears"); rd(CNT, 8'd3, "R7 new top 4");

    // R2 reserved code behaves as normal
    wr(CTRL, 8'h06); rd(CTRL, 8'h06, "R12 mode field");
    wr(CNT, 8'hFE);
    tk(1); expect_it(K_OVF, 0, "R2 reserved no ovf at FE");
    tk(1); expect_it(K_OVF, 1, "R2 reserved ovf at FF");
    rd(CNT, 8'd0, "R2 reserved wrap");

    done = 1;
    finish_run();
  end
endmodule